// File: doc/BRIEF.md
# Half-Flash Converter Bus Sequencer

This block is the digital control core of an eight-bit, multi-channel half-flash analog-to-digital converter, modelled cycle by cycle at its bus pins. A host reaches it with active-low chip select, read and write strobes, a three-bit channel address, a mode input and an active-low power-down input. The analog front end is replaced by a flat vector with one sample word per channel. Each half of the conversion takes a parameterized number of clock cycles. The result reaches the output register one nibble at a time: the upper nibble (the top bits of the held sample) first, then the lower nibble.

The mode input selects one of two protocols. With mode low, a read strobe both starts the conversion and collects the result. An open-drain style ready flag holds the host in a wait state until the result is complete. With mode high, a write strobe starts the conversion and its trailing edge captures the upper nibble. The lower nibble then either completes on its own timer or is completed at once by an early read. Tying the write and read strobes together gives pipelined operation, where each strobe starts a new conversion and returns the previous result. The highest address selects an internal reference channel that always converts to all ones.

All inputs are sampled on the rising clock edge. An "edge" of a strobe means the first clock edge at which the new level is seen. The timing stated below counts clock edges from that edge.

Top module: `halfflash_bus_seq`

## Requirements
- R1: While reset is asserted and directly after it, int_n_o=1, rdy_pull_o=0, hold_o=0, dropped_o=0 and data_o=0.
- R2: A read or write strobe counts only while cs_n_i is low. Activity on rd_n_i or wr_n_i with cs_n_i high starts nothing: hold_o stays 0 and int_n_o stays 1.
- R3: With mode_i=0, a conversion starts at the edge where cs_n_i and rd_n_i are first both low, and hold_o is 1 after that edge k. data_o[7:4] takes the sample's top four bits at edge k+HI_CYC. At edge k+HI_CYC+LO_CYC, data_o[3:0] takes the bottom four bits, int_n_o falls and hold_o falls.
- R4: With mode_i=0, rdy_pull_o becomes 1 after a falling edge of cs_n_i. It returns to 0 at the end of a conversion or on a rising edge of cs_n_i. With mode_i=1, rdy_pull_o is 0 one cycle later and stays 0.
- R5: int_n_o returns to 1 at a rising edge of cs_n_i or of rd_n_i, unless a conversion ends at that same edge.
- R6: With mode_i=1, a conversion starts at the edge where cs_n_i and wr_n_i are first both low, and hold_o rises. At the edge m where that write strobe ends, data_o[7:4] is loaded. At edge m+LO_CYC, data_o[3:0] is loaded, int_n_o falls and hold_o falls. With mode_i=0, wr_n_i has no effect.
- R7: With mode_i=1, a read strobe that begins during the lower phase completes the conversion at that same edge: data_o[3:0] is loaded, int_n_o falls and hold_o falls.
- R8: With mode_i=1, write and read strobes that begin together on an idle block start a new conversion while data_o still shows the previous result.
- R9: The sample of channel a is sample_i[8a+7:8a], taken when the conversion starts. Address 7 converts to 8'hFF whatever sample_i holds for channel 7.
- R10: data_oe_o is 1 exactly while cs_n_i and rd_n_i are both low.
- R11: pd_n_i low sets int_n_o=1 and hold_o=0 at the next edge, releases rdy_pull_o, clears dropped_o and ignores all strobes. After pd_n_i is first seen high at edge p, a start is accepted only at edge p+WAKE_CYC+1 or later.
- R12: A start strobe that arrives during wake-up or during a conversion is ignored and sets dropped_o at that edge. The next accepted start clears dropped_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low (used in write-read mode only) |
| mode_i | input | 1 | 0 = read mode, 1 = write-read mode |
| pd_n_i | input | 1 | Power-down, active low |
| addr_i | input | 3 | Channel address |
| sample_i | input | 64 | One 8-bit sample per channel, channel 0 in the low byte |
| int_n_o | output | 1 | End-of-conversion flag, active low |
| rdy_pull_o | output | 1 | 1 while the ready line is pulled low |
| hold_o | output | 1 | 1 while the track/hold is holding |
| dropped_o | output | 1 | A start request was ignored since the last accepted start |
| data_o | output | 8 | Output register, straight binary |
| data_oe_o | output | 1 | Output driver enable for data_o |

## Verification
A behavioural cycle model in the bench predicts every output on every clock. Read-mode conversions are run with chip select and read falling together and with chip select leading, which separates the ready flag's set condition from its release. Write-read conversions are run three ways: left to finish on their timer, cut short by an early read, and with the strobes tied together. These three patterns separate the lower-nibble timer path, the immediate completion path and the old-data-out behaviour. Extra cases cover strobes during a conversion, power-down in the middle of a conversion, starts during wake-up and the reference address with a decoy sample. They show whether ignored requests leave the held sample and the output register alone.

// File: rtl/halfflash_pkg.sv
package halfflash_pkg;

   typedef enum logic [2:0] {
      SQ_OFF     = 3'd0,
      SQ_WAKE    = 3'd1,
      SQ_IDLE    = 3'd2,
      SQ_UPPER   = 3'd3,
      SQ_WSTROBE = 3'd4,
      SQ_LOWER   = 3'd5
   } seq_state_e;

   typedef struct packed {
      logic cs_fall;
      logic cs_rise;
      logic rd_rise;
      logic rd_strobe_on;
      logic wr_strobe_on;
      logic wr_strobe_off;
   } bus_edges_t;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/halfflash_bus_edges.sv
module halfflash_bus_edges
   import halfflash_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n_i,
   input  logic       rd_n_i,
   input  logic       wr_n_i,
   output bus_edges_t edges_o
);

   logic cs_q, rd_q, wr_q;
   logic rd_act, wr_act, rd_act_q, wr_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= 1'b1;
         rd_q <= 1'b1;
         wr_q <= 1'b1;
      end else begin
         cs_q <= cs_n_i;
         rd_q <= rd_n_i;
         wr_q <= wr_n_i;
      end
   end

   // a strobe is only qualified while chip select is low
   assign rd_act   = !cs_n_i && !rd_n_i;
   assign wr_act   = !cs_n_i && !wr_n_i;
   assign rd_act_q = !cs_q && !rd_q;
   assign wr_act_q = !cs_q && !wr_q;

   always_comb begin
      edges_o.cs_fall       = cs_q && !cs_n_i;
      edges_o.cs_rise       = !cs_q && cs_n_i;
      edges_o.rd_rise       = !rd_q && rd_n_i;
      edges_o.rd_strobe_on  = rd_act && !rd_act_q;
      edges_o.wr_strobe_on  = wr_act && !wr_act_q;
      edges_o.wr_strobe_off = !wr_act && wr_act_q;
   end

endmodule

// File: rtl/halfflash_seq_ctrl.sv
module halfflash_seq_ctrl
   import halfflash_pkg::*;
#(
   parameter int unsigned HI_CYC   = 3,
   parameter int unsigned LO_CYC   = 4,
   parameter int unsigned WAKE_CYC = 5,
   parameter int unsigned CNT_W    = 3
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_i,
   input  logic       pd_n_i,
   input  bus_edges_t edges_i,
   output logic       start_o,
   output logic       latch_hi_o,
   output logic       latch_lo_o,
   output logic       hold_o,
   output logic       int_n_o,
   output logic       rdy_pull_o,
   output logic       dropped_o
);

   localparam logic [CNT_W-1:0] HI_LOAD   = CNT_W'(HI_CYC - 1);
   localparam logic [CNT_W-1:0] LO_LOAD   = CNT_W'(LO_CYC - 1);
   localparam logic [CNT_W-1:0] WAKE_LOAD = CNT_W'(WAKE_CYC - 1);

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             start_req, early_rd, cnt_done;
   logic             eoc, drop_evt;

   assign start_req = mode_i ? edges_i.wr_strobe_on : edges_i.rd_strobe_on;
   assign early_rd  = mode_i && edges_i.rd_strobe_on;
   assign cnt_done  = (cnt_q == '0);

   always_comb begin
      state_d    = state_q;
      cnt_d      = cnt_q;
      start_o    = 1'b0;
      latch_hi_o = 1'b0;
      latch_lo_o = 1'b0;
      eoc        = 1'b0;
      drop_evt   = 1'b0;
      if (!pd_n_i) begin
         state_d = SQ_OFF;
         cnt_d   = '0;
      end else begin
         unique case (state_q)
            SQ_OFF: begin
               state_d = SQ_WAKE;
               cnt_d   = WAKE_LOAD;
            end
            SQ_WAKE: begin
               drop_evt = start_req;
               if (cnt_done) state_d = SQ_IDLE;
               else          cnt_d   = cnt_q - CNT_W'(1);
            end
            SQ_IDLE: begin
               if (start_req) begin
                  start_o = 1'b1;
                  if (mode_i) begin
                     state_d = SQ_WSTROBE;
                  end else begin
                     state_d = SQ_UPPER;
                     cnt_d   = HI_LOAD;
                  end
               end
            end
            SQ_UPPER: begin
               drop_evt = start_req;
               if (cnt_done) begin
                  latch_hi_o = 1'b1;
                  state_d    = SQ_LOWER;
                  cnt_d      = LO_LOAD;
               end else begin
                  cnt_d = cnt_q - CNT_W'(1);
               end
            end
            SQ_WSTROBE: begin
               drop_evt = start_req;
               if (edges_i.wr_strobe_off) begin
                  latch_hi_o = 1'b1;
                  state_d    = SQ_LOWER;
                  cnt_d      = LO_LOAD;
               end
            end
            SQ_LOWER: begin
               drop_evt = start_req;
               if (cnt_done || early_rd) begin
                  latch_lo_o = 1'b1;
                  eoc        = 1'b1;
                  state_d    = SQ_IDLE;
               end else begin
                  cnt_d = cnt_q - CNT_W'(1);
               end
            end
            default: begin
               state_d = SQ_OFF;
               cnt_d   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SQ_OFF;
         cnt_q      <= '0;
         hold_o     <= 1'b0;
         int_n_o    <= 1'b1;
         rdy_pull_o <= 1'b0;
         dropped_o  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         if (!pd_n_i) begin
            hold_o     <= 1'b0;
            int_n_o    <= 1'b1;
            rdy_pull_o <= 1'b0;
            dropped_o  <= 1'b0;
         end else begin
            if (start_o)  hold_o <= 1'b1;
            else if (eoc) hold_o <= 1'b0;

            if (eoc)                                      int_n_o <= 1'b0;
            else if (edges_i.cs_rise || edges_i.rd_rise)  int_n_o <= 1'b1;

            if (mode_i)                              rdy_pull_o <= 1'b0;
            else if (edges_i.cs_fall)                rdy_pull_o <= 1'b1;
            else if (eoc || edges_i.cs_rise)         rdy_pull_o <= 1'b0;

            if (start_o)       dropped_o <= 1'b0;
            else if (drop_evt) dropped_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/halfflash_result_path.sv
module halfflash_result_path #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_CH   = 8,
   parameter bit          REF_LAST = 1'b1,
   parameter int unsigned ADDR_W   = 3
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [NUM_CH*DATA_W-1:0] sample_i,
   input  logic                     start_i,
   input  logic                     latch_hi_i,
   input  logic                     latch_lo_i,
   output logic [DATA_W-1:0]        data_o
);

   localparam int unsigned NIB_W = DATA_W / 2;

   logic [DATA_W-1:0] picked;
   logic [DATA_W-1:0] held_q;
   logic [DATA_W-1:0] chan [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      if (REF_LAST && (c == NUM_CH - 1)) begin : g_ref
         assign chan[c] = '1;
      end else begin : g_ext
         assign chan[c] = sample_i[c*DATA_W +: DATA_W];
      end
   end

   always_comb begin
      picked = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr_i == ADDR_W'(i)) picked = chan[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         data_o <= '0;
      end else begin
         if (start_i)    held_q                <= picked;
         if (latch_hi_i) data_o[DATA_W-1:NIB_W] <= held_q[DATA_W-1:NIB_W];
         if (latch_lo_i) data_o[NIB_W-1:0]      <= held_q[NIB_W-1:0];
      end
   end

endmodule

// File: rtl/halfflash_bus_seq.sv
module halfflash_bus_seq
   import halfflash_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_CH   = 8,
   parameter int unsigned HI_CYC   = 3,
   parameter int unsigned LO_CYC   = 4,
   parameter int unsigned WAKE_CYC = 5,
   parameter bit          REF_LAST = 1'b1,
   localparam int unsigned ADDR_W  = $clog2(NUM_CH)
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n_i,
   input  logic                     rd_n_i,
   input  logic                     wr_n_i,
   input  logic                     mode_i,
   input  logic                     pd_n_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [NUM_CH*DATA_W-1:0] sample_i,
   output logic                     int_n_o,
   output logic                     rdy_pull_o,
   output logic                     hold_o,
   output logic                     dropped_o,
   output logic [DATA_W-1:0]        data_o,
   output logic                     data_oe_o
);

   localparam int unsigned MAX_CYC = max3(HI_CYC, LO_CYC, WAKE_CYC);
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   initial begin
      if (DATA_W < 2 || (DATA_W % 2) != 0)
         $error("DATA_W must be even and at least 2");
      if (NUM_CH < 2)
         $error("NUM_CH must be at least 2");
      if (HI_CYC < 1 || LO_CYC < 1 || WAKE_CYC < 1)
         $error("phase and wake lengths must be at least 1");
   end

   bus_edges_t edges;
   logic       start, latch_hi, latch_lo;

   halfflash_bus_edges u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n_i  (cs_n_i),
      .rd_n_i  (rd_n_i),
      .wr_n_i  (wr_n_i),
      .edges_o (edges)
   );

   halfflash_seq_ctrl #(
      .HI_CYC   (HI_CYC),
      .LO_CYC   (LO_CYC),
      .WAKE_CYC (WAKE_CYC),
      .CNT_W    (CNT_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode_i),
      .pd_n_i     (pd_n_i),
      .edges_i    (edges),
      .start_o    (start),
      .latch_hi_o (latch_hi),
      .latch_lo_o (latch_lo),
      .hold_o     (hold_o),
      .int_n_o    (int_n_o),
      .rdy_pull_o (rdy_pull_o),
      .dropped_o  (dropped_o)
   );

   halfflash_result_path #(
      .DATA_W   (DATA_W),
      .NUM_CH   (NUM_CH),
      .REF_LAST (REF_LAST),
      .ADDR_W   (ADDR_W)
   ) u_result (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (addr_i),
      .sample_i   (sample_i),
      .start_i    (start),
      .latch_hi_i (latch_hi),
      .latch_lo_i (latch_lo),
      .data_o     (data_o)
   );

   assign data_oe_o = !cs_n_i && !rd_n_i;

endmodule

// File: rtl/halfflash_bus_seq_chk.sv
module halfflash_bus_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_n_i,
   input logic rd_n_i,
   input logic mode_i,
   input logic pd_n_i,
   input logic int_n_o,
   input logic rdy_pull_o,
   input logic hold_o,
   input logic dropped_o
);

   // R2: holding needs a start, and a start needs chip select low
   assert_cs_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_i && !hold_o) |=> !hold_o);

   // R2: hold rises only after an edge that saw chip select low
   assert_start_needs_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_o) |-> $past(!cs_n_i));

   // R3: the end-of-conversion flag falls together with the release of hold
   assert_eoc_releases_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_n_o) |-> !hold_o);

   // R4: no ready pull in write-read mode
   assert_no_ready_wr_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_i |=> !rdy_pull_o);

   // R5: a rising read strobe outside a conversion releases the flag
   assert_int_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(rd_n_i) && !hold_o) |=> int_n_o);

   // R11: power-down clears the control outputs
   assert_powerdown_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n_i |=> (int_n_o && !hold_o && !rdy_pull_o && !dropped_o));

   // R12: an accepted start never coincides with a newly dropped request
   assert_drop_not_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dropped_o) |-> !$rose(hold_o));

endmodule

bind halfflash_bus_seq halfflash_bus_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n_i     (cs_n_i),
   .rd_n_i     (rd_n_i),
   .mode_i     (mode_i),
   .pd_n_i     (pd_n_i),
   .int_n_o    (int_n_o),
   .rdy_pull_o (rdy_pull_o),
   .hold_o     (hold_o),
   .dropped_o  (dropped_o)
);

// File: tb/halfflash_bus_seq_test.sv
`timescale 1ns/1ps
module halfflash_bus_seq_test;

   localparam int HI = 3, LO = 4, WK = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mode = 1'b0, pd_n = 1'b1;
   logic [2:0]  addr = 3'd0;
   logic [63:0] samples = '0;
   logic        int_n, rdy_pull, hold, dropped, data_oe;
   logic [7:0]  data;

   int checks = 0, fails = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   halfflash_bus_seq #(.HI_CYC(HI), .LO_CYC(LO), .WAKE_CYC(WK)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
      .mode_i(mode), .pd_n_i(pd_n), .addr_i(addr), .sample_i(samples),
      .int_n_o(int_n), .rdy_pull_o(rdy_pull), .hold_o(hold), .dropped_o(dropped),
      .data_o(data), .data_oe_o(data_oe)
   );

   // behavioural model: phase 0 off, 1 wake, 2 idle, 3 upper, 4 write held, 5 lower
   int         m_phase, m_left;
   logic       m_hold, m_int, m_rdy, m_drop;
   logic [7:0] m_data, m_held;
   logic       p_cs, p_rd, p_wr;

   function automatic logic [7:0] pick(input logic [2:0] a);
      if (a == 3'd7) return 8'hFF;
      return samples[a*8 +: 8];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_left = 0; m_hold = 0; m_int = 1; m_rdy = 0; m_drop = 0;
         m_data = 8'h00; m_held = 8'h00; p_cs = 1; p_rd = 1; p_wr = 1;
      end else begin
         bit csf, csr, rdr, rdon, wron, wroff, req, st, eoc, drp, lhi, llo;
         csf   = p_cs && !cs_n;
         csr   = !p_cs && cs_n;
         rdr   = !p_rd && rd_n;
         rdon  = (!cs_n && !rd_n) && !(!p_cs && !p_rd);
         wron  = (!cs_n && !wr_n) && !(!p_cs && !p_wr);
         wroff = !(!cs_n && !wr_n) && (!p_cs && !p_wr);
         req   = mode ? wron : rdon;
         st = 0; eoc = 0; drp = 0; lhi = 0; llo = 0;
         if (!pd_n) begin
            m_phase = 0; m_hold = 0; m_int = 1; m_rdy = 0; m_drop = 0;
         end else begin
            case (m_phase)
               0: begin m_phase = 1; m_left = WK; end
               1: begin drp = req; if (m_left == 1) m_phase = 2; else m_left--; end
               2: if (req) begin
                     st = 1; m_held = pick(addr);
                     if (mode) m_phase = 4; else begin m_phase = 3; m_left = HI; end
                  end
               3: begin drp = req;
                     if (m_left == 1) begin lhi = 1; m_phase = 5; m_left = LO; end
                     else m_left--;
                  end
               4: begin drp = req;
                     if (wroff) begin lhi = 1; m_phase = 5; m_left = LO; end
                  end
               default: begin drp = req;
                     if ((mode && rdon) || m_left == 1) begin llo = 1; eoc = 1; m_phase = 2; end
                     else m_left--;
                  end
            endcase
            if (st) m_hold = 1; else if (eoc) m_hold = 0;
            if (eoc) m_int = 0; else if (csr || rdr) m_int = 1;
            if (mode) m_rdy = 0; else if (csf) m_rdy = 1; else if (eoc || csr) m_rdy = 0;
            if (st) m_drop = 0; else if (drp) m_drop = 1;
            if (lhi) m_data[7:4] = m_held[7:4];
            if (llo) m_data[3:0] = m_held[3:0];
         end
         p_cs = cs_n; p_rd = rd_n; p_wr = wr_n;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // compare against the model on every clock
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(int_n == m_int,    "R5",  "int_n per cycle",    int_n, m_int);
         check(rdy_pull == m_rdy, "R4",  "rdy_pull per cycle", rdy_pull, m_rdy);
         check(hold == m_hold,    "R3",  "hold per cycle",     hold, m_hold);
         check(dropped == m_drop, "R12", "dropped per cycle",  dropped, m_drop);
         check(data == m_data,    "R6",  "data per cycle",     data, m_data);
         check(data_oe == (!cs_n && !rd_n), "R10", "data_oe per cycle",
               data_oe, !cs_n && !rd_n);
      end
   end

   task automatic drive(input logic c, input logic r, input logic w);
      @(posedge clk); #1;
      cs_n = c; rd_n = r; wr_n = w;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // wait until the last drive has been seen at an edge, then sample
   task automatic settle();
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      for (int k = 0; k < 8; k++) samples[k*8 +: 8] = 8'((k * 37 + 90) & 255);
      samples[7*8 +: 8] = 8'h3C;
      repeat (3) @(negedge clk);
      check(int_n && !rdy_pull && !hold && !dropped && data == 8'h00, "R1",
            "reset state", {int_n, rdy_pull, hold, dropped, data}, 12'h800);
      @(posedge clk); #1; rst_n = 1'b1;
      idle(WK + 3);

      // R2: strobes with chip select high
      mode = 0; drive(1, 0, 1); drive(1, 1, 1);
      mode = 1; drive(1, 1, 0); drive(1, 1, 1);
      settle();
      check(!hold && int_n, "R2", "no start with cs high", {hold, int_n}, 2'b01);

      // R3: read mode, cs and rd together, channel 2
      mode = 0; addr = 3'd2;
      drive(0, 0, 1);
      idle(HI + LO + 2);
      @(negedge clk);
      check(data == samples[2*8 +: 8] && !int_n && !hold, "R3", "read-mode result",
            data, samples[2*8 +: 8]);
      drive(0, 1, 1);
      settle();
      check(int_n, "R5", "int released by rd rise", int_n, 1);
      drive(1, 1, 1);

      // R4: cs leads rd; wr toggles are ignored in read mode (R6)
      drive(0, 1, 1);
      settle();
      check(rdy_pull, "R4", "ready pulled after cs fall", rdy_pull, 1);
      drive(0, 1, 0); drive(0, 1, 1);
      settle();
      check(!hold, "R6", "wr ignored in read mode", hold, 0);
      addr = 3'd4; drive(0, 0, 1);
      idle(HI + LO + 2);
      @(negedge clk);
      check(!rdy_pull && data == samples[4*8 +: 8], "R4", "ready released at end",
            rdy_pull, 0);
      drive(1, 1, 1); idle(2);

      // R6: write-read conversion left to its timer, channel 5
      mode = 1; addr = 3'd5;
      drive(0, 1, 0);
      settle();
      check(hold, "R6", "hold after write fall", hold, 1);
      drive(0, 1, 0); drive(0, 1, 1);
      idle(LO + 2);
      drive(0, 0, 1);
      settle();
      check(data == samples[5*8 +: 8] && data_oe && !int_n, "R6", "write-read result",
            data, samples[5*8 +: 8]);
      drive(1, 1, 1); idle(2);

      // R7: early read during the lower phase, channel 1
      addr = 3'd1;
      drive(0, 1, 0); drive(0, 1, 1); drive(0, 0, 1);
      settle();
      check(data == samples[1*8 +: 8] && !int_n && !hold, "R7", "early read completes",
            data, samples[1*8 +: 8]);
      drive(1, 1, 1); idle(2);

      // R8: pipelined strobes, channel 3 then reference channel
      addr = 3'd3; drive(0, 0, 0);
      settle();
      check(hold && data == samples[1*8 +: 8] && data_oe, "R8", "old data during new start",
            data, samples[1*8 +: 8]);
      drive(0, 1, 1); idle(LO + 2);
      addr = 3'd7; drive(0, 0, 0);
      settle();
      check(data == samples[3*8 +: 8], "R8", "pipelined returns previous", data,
            samples[3*8 +: 8]);
      drive(0, 1, 1); idle(LO + 2);
      drive(0, 0, 1);
      settle();
      check(data == 8'hFF, "R9", "reference channel all ones", data, 8'hFF);
      drive(1, 1, 1); idle(2);

      // R12: second read strobe during a read-mode conversion is dropped
      mode = 0; addr = 3'd6; samples[6*8 +: 8] = 8'hA5;
      drive(0, 0, 1); drive(0, 1, 1); drive(0, 0, 1);
      settle();
      check(dropped, "R12", "busy start flagged", dropped, 1);
      idle(HI + LO + 2);
      @(negedge clk);
      check(data == 8'hA5, "R9", "channel 6 sample", data, 8'hA5);
      drive(1, 1, 1);
      addr = 3'd0; samples[7:0] = 8'h00;
      drive(0, 0, 1);
      settle();
      check(!dropped, "R12", "accepted start clears flag", dropped, 0);
      idle(HI + LO + 2);
      @(negedge clk);
      check(data == 8'h00, "R9", "channel 0 zero sample", data, 8'h00);
      drive(1, 1, 1);

      // R11: power-down during a conversion, then start during wake-up
      drive(0, 0, 1); idle(1);
      pd_n = 0; idle(3);
      @(negedge clk);
      check(!hold && int_n && !rdy_pull, "R11", "power-down idles", {hold, int_n, rdy_pull}, 3'b010);
      drive(1, 1, 1);
      pd_n = 1;
      drive(0, 0, 1);
      settle();
      check(!hold && dropped, "R11", "start during wake ignored", {hold, dropped}, 2'b01);
      drive(1, 1, 1); idle(WK + 2);
      addr = 3'd5; drive(0, 0, 1);
      settle();
      check(hold && !dropped, "R11", "start accepted after wake", {hold, dropped}, 2'b10);
      idle(HI + LO + 2);
      drive(1, 1, 1); idle(3);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule